// File: doc/BRIEF.md
# Collision-Aware Dual-Port RAM

A true dual-port synchronous RAM with both ports on one clock. Each port has an enable, a write enable, an address, write data and a registered read output with one cycle of latency. Each port also has its own write-mode parameter. The mode decides what the port's own output shows in the cycle after it writes: the word that was stored before, the word being written, or the output it already had.

When both ports are enabled on the same address in the same cycle, the block applies a fixed resolution rule. Two reads are harmless. Two writes leave the word unknown, and both outputs are unknown too. When one port writes and the other reads, the write always lands. The reader sees the old word only if the writer is in read-first mode; otherwise the reader gets an unknown value. Two registered flags, aligned with the read data, report a collision and a double-write corruption so that a testbench or monitor can react.

Top module: `cdp_ram`

## Requirements
- R1: While rst_ni is low, and after it is released, both read outputs and both flags are zero until the first enabled access.
- R2: An enabled read (we=0) presents the stored word at its port's output one clock later.
- R3: A port in read-first mode (mode code 0) that writes shows the word stored before the write on its output, and the memory takes the new word.
- R4: A port in write-first mode (mode code 1) that writes shows its own write data on its output one clock later.
- R5: A port in no-change mode (mode code 2) that writes leaves its output unchanged, and the memory takes the new word.
- R6: A port whose enable is low neither reads nor writes, even with its write enable high, and its output keeps its value.
- R7: collide_o is high in the cycle after both ports are enabled with equal addresses, and low after any other cycle.
- R8: When both ports read the same address, both outputs show the stored word and the memory is unchanged.
- R9: In a write/read collision the writer's data is stored and the writer's output follows its own mode. The reader sees the old word if the writer is in read-first mode, and an unknown value otherwise.
- R10: When both ports write the same address, the word and both outputs become unknown and corrupt_o is high one cycle later. Writes to different addresses both land and raise no flag.
- R11: The write mode of each port is set by its own parameter, MODE_A and MODE_B, and both default to read-first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared clock |
| rst_ni | input | 1 | Active-low asynchronous reset of outputs and flags |
| a_en_i | input | 1 | Port A enable |
| a_we_i | input | 1 | Port A write enable, 1 = write |
| a_addr_i | input | AW | Port A address |
| a_wdata_i | input | DW | Port A write data |
| a_rdata_o | output | DW | Port A registered read data |
| b_en_i | input | 1 | Port B enable |
| b_we_i | input | 1 | Port B write enable, 1 = write |
| b_addr_i | input | AW | Port B address |
| b_wdata_i | input | DW | Port B write data |
| b_rdata_o | output | DW | Port B registered read data |
| collide_o | output | 1 | Same-address access by both ports in the previous cycle |
| corrupt_o | output | 1 | Both ports wrote the same address in the previous cycle |

## Verification
The assertions take for granted that every input is a known 0 or 1 at each rising edge and that addresses stay below DEPTH. Data values, however, may be unknown, so the data checks compare with case equality. The stimulus drives every input from reset onward, changes it only on falling edges, and draws addresses from a few in-range words so that collisions happen often. The bench tracks unknown words in its model and skips data comparison wherever the rules leave the result undefined. It still checks both flags in those cycles.

// File: rtl/cdp_ram_pkg.sv
package cdp_ram_pkg;
  typedef enum logic [1:0] {
    WM_READ_FIRST  = 2'd0,
    WM_WRITE_FIRST = 2'd1,
    WM_NO_CHANGE   = 2'd2
  } wr_mode_e;
endpackage

// File: rtl/cdp_ram_store.sv
module cdp_ram_store #(
  parameter int DEPTH = 256,
  parameter int DW    = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          a_wr_i,
  input  logic [AW-1:0] a_addr_i,
  input  logic [DW-1:0] a_wdata_i,
  input  logic          b_wr_i,
  input  logic [AW-1:0] b_addr_i,
  input  logic [DW-1:0] b_wdata_i,
  input  logic          clash_i,
  output logic [DW-1:0] a_old_o,
  output logic [DW-1:0] b_old_o
);
  logic [DW-1:0] mem_q [DEPTH];

  assign a_old_o = mem_q[a_addr_i];
  assign b_old_o = mem_q[b_addr_i];

  always_ff @(posedge clk_i) begin
    if (clash_i) begin
      mem_q[a_addr_i] <= 'x;
    end else begin
      if (a_wr_i) mem_q[a_addr_i] <= a_wdata_i;
      if (b_wr_i) mem_q[b_addr_i] <= b_wdata_i;
    end
  end
endmodule

// File: rtl/cdp_ram_arb.sv
module cdp_ram_arb
  import cdp_ram_pkg::*;
#(
  parameter int       AW     = 8,
  parameter wr_mode_e MODE_A = WM_READ_FIRST,
  parameter wr_mode_e MODE_B = WM_READ_FIRST
) (
  input  logic          a_en_i,
  input  logic          a_we_i,
  input  logic [AW-1:0] a_addr_i,
  input  logic          b_en_i,
  input  logic          b_we_i,
  input  logic [AW-1:0] b_addr_i,
  output logic          hit_o,
  output logic          clash_o,
  output logic          a_unk_o,
  output logic          b_unk_o
);
  localparam bit A_SAFE = (MODE_A == WM_READ_FIRST);
  localparam bit B_SAFE = (MODE_B == WM_READ_FIRST);

  assign hit_o   = a_en_i & b_en_i & (a_addr_i == b_addr_i);
  assign clash_o = hit_o & a_we_i & b_we_i;
  // reader is poisoned unless the writer samples the array before updating it
  assign a_unk_o = clash_o | (hit_o & ~a_we_i & b_we_i & ~B_SAFE);
  assign b_unk_o = clash_o | (hit_o & ~b_we_i & a_we_i & ~A_SAFE);
endmodule

// File: rtl/cdp_ram_port.sv
module cdp_ram_port
  import cdp_ram_pkg::*;
#(
  parameter int       DW   = 16,
  parameter wr_mode_e MODE = WM_READ_FIRST
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] old_i,
  input  logic          unk_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] rdata_q;
  logic [DW-1:0] wr_view;
  logic [DW-1:0] rdata_d;

  generate
    if (MODE == WM_WRITE_FIRST) begin : g_wf
      assign wr_view = wdata_i;
    end else if (MODE == WM_NO_CHANGE) begin : g_nc
      assign wr_view = rdata_q;
    end else begin : g_rf
      assign wr_view = old_i;
    end
  endgenerate

  always_comb begin
    rdata_d = we_i ? wr_view : old_i;
    if (unk_i) rdata_d = 'x;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (en_i) rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/cdp_ram.sv
module cdp_ram
  import cdp_ram_pkg::*;
#(
  parameter int       DEPTH  = 256,
  parameter int       DW     = 16,
  parameter wr_mode_e MODE_A = WM_READ_FIRST,
  parameter wr_mode_e MODE_B = WM_READ_FIRST,
  localparam int      AW     = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          a_en_i,
  input  logic          a_we_i,
  input  logic [AW-1:0] a_addr_i,
  input  logic [DW-1:0] a_wdata_i,
  output logic [DW-1:0] a_rdata_o,
  input  logic          b_en_i,
  input  logic          b_we_i,
  input  logic [AW-1:0] b_addr_i,
  input  logic [DW-1:0] b_wdata_i,
  output logic [DW-1:0] b_rdata_o,
  output logic          collide_o,
  output logic          corrupt_o
);
  logic          hit, clash, a_unk, b_unk;
  logic [DW-1:0] a_old, b_old;
  logic          collide_q, corrupt_q;

  cdp_ram_arb #(.AW(AW), .MODE_A(MODE_A), .MODE_B(MODE_B)) u_arb (
    .a_en_i  (a_en_i),
    .a_we_i  (a_we_i),
    .a_addr_i(a_addr_i),
    .b_en_i  (b_en_i),
    .b_we_i  (b_we_i),
    .b_addr_i(b_addr_i),
    .hit_o   (hit),
    .clash_o (clash),
    .a_unk_o (a_unk),
    .b_unk_o (b_unk)
  );

  cdp_ram_store #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_store (
    .clk_i    (clk_i),
    .a_wr_i   (a_en_i & a_we_i),
    .a_addr_i (a_addr_i),
    .a_wdata_i(a_wdata_i),
    .b_wr_i   (b_en_i & b_we_i),
    .b_addr_i (b_addr_i),
    .b_wdata_i(b_wdata_i),
    .clash_i  (clash),
    .a_old_o  (a_old),
    .b_old_o  (b_old)
  );

  cdp_ram_port #(.DW(DW), .MODE(MODE_A)) u_port_a (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (a_en_i),
    .we_i   (a_we_i),
    .wdata_i(a_wdata_i),
    .old_i  (a_old),
    .unk_i  (a_unk),
    .rdata_o(a_rdata_o)
  );

  cdp_ram_port #(.DW(DW), .MODE(MODE_B)) u_port_b (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (b_en_i),
    .we_i   (b_we_i),
    .wdata_i(b_wdata_i),
    .old_i  (b_old),
    .unk_i  (b_unk),
    .rdata_o(b_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      collide_q <= 1'b0;
      corrupt_q <= 1'b0;
    end else begin
      collide_q <= hit;
      corrupt_q <= clash;
    end
  end

  assign collide_o = collide_q;
  assign corrupt_o = corrupt_q;
endmodule

// File: rtl/cdp_ram_chk.sv
module cdp_ram_chk
  import cdp_ram_pkg::*;
#(
  parameter int       DW     = 16,
  parameter int       AW     = 8,
  parameter wr_mode_e MODE_A = WM_READ_FIRST,
  parameter wr_mode_e MODE_B = WM_READ_FIRST
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          a_en_i,
  input logic          a_we_i,
  input logic [AW-1:0] a_addr_i,
  input logic [DW-1:0] a_wdata_i,
  input logic [DW-1:0] a_rdata_o,
  input logic          b_en_i,
  input logic          b_we_i,
  input logic [AW-1:0] b_addr_i,
  input logic [DW-1:0] b_wdata_i,
  input logic [DW-1:0] b_rdata_o,
  input logic          collide_o,
  input logic          corrupt_o
);
  logic same, both_wr;
  assign same    = a_en_i && b_en_i && (a_addr_i == b_addr_i);
  assign both_wr = same && a_we_i && b_we_i;

  p_flag_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    same |=> collide_o);
  p_flag_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !same |=> !collide_o);
  p_corrupt_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    corrupt_o |-> collide_o);
  p_hold_a_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !a_en_i |=> $stable(a_rdata_o));
  p_hold_b_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !b_en_i |=> $stable(b_rdata_o));
  p_rf_a_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (MODE_A == WM_READ_FIRST && same && a_we_i && !b_we_i) |=> (b_rdata_o === a_rdata_o));
  p_rf_b_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (MODE_B == WM_READ_FIRST && same && b_we_i && !a_we_i) |=> (a_rdata_o === b_rdata_o));
  p_wf_a_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (MODE_A == WM_WRITE_FIRST && a_en_i && a_we_i && !both_wr) |=> (a_rdata_o === $past(a_wdata_i)));
  p_wf_b_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (MODE_B == WM_WRITE_FIRST && b_en_i && b_we_i && !both_wr) |=> (b_rdata_o === $past(b_wdata_i)));
  p_nc_a_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (MODE_A == WM_NO_CHANGE && a_en_i && a_we_i && !both_wr) |=> $stable(a_rdata_o));
  p_nc_b_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (MODE_B == WM_NO_CHANGE && b_en_i && b_we_i && !both_wr) |=> $stable(b_rdata_o));
endmodule

bind cdp_ram cdp_ram_chk #(.DW(DW), .AW(AW), .MODE_A(MODE_A), .MODE_B(MODE_B)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .a_en_i   (a_en_i),
  .a_we_i   (a_we_i),
  .a_addr_i (a_addr_i),
  .a_wdata_i(a_wdata_i),
  .a_rdata_o(a_rdata_o),
  .b_en_i   (b_en_i),
  .b_we_i   (b_we_i),
  .b_addr_i (b_addr_i),
  .b_wdata_i(b_wdata_i),
  .b_rdata_o(b_rdata_o),
  .collide_o(collide_o),
  .corrupt_o(corrupt_o)
);

// File: tb/cdp_ram_bench.sv
module cdp_ram_bench;
  import cdp_ram_pkg::*;
  localparam int DEPTH = 256;
  localparam int DW    = 16;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic          ae = 0, awe = 0, be = 0, bwe = 0;
  logic [AW-1:0] aa = '0, ba = '0;
  logic [DW-1:0] ad = '0, bd = '0;
  logic [DW-1:0] ra [2];
  logic [DW-1:0] rb [2];
  logic          col [2];
  logic          cor [2];

  // instance 0: default modes (both read-first); instance 1: A write-first, B no-change
  cdp_ram #(.DEPTH(DEPTH), .DW(DW)) u_cdp_ram (
    .clk_i(clk), .rst_ni(rst_ni),
    .a_en_i(ae), .a_we_i(awe), .a_addr_i(aa), .a_wdata_i(ad), .a_rdata_o(ra[0]),
    .b_en_i(be), .b_we_i(bwe), .b_addr_i(ba), .b_wdata_i(bd), .b_rdata_o(rb[0]),
    .collide_o(col[0]), .corrupt_o(cor[0]));

  cdp_ram #(.DEPTH(DEPTH), .DW(DW), .MODE_A(WM_WRITE_FIRST), .MODE_B(WM_NO_CHANGE)) u_cdp_ram_mix (
    .clk_i(clk), .rst_ni(rst_ni),
    .a_en_i(ae), .a_we_i(awe), .a_addr_i(aa), .a_wdata_i(ad), .a_rdata_o(ra[1]),
    .b_en_i(be), .b_we_i(bwe), .b_addr_i(ba), .b_wdata_i(bd), .b_rdata_o(rb[1]),
    .collide_o(col[1]), .corrupt_o(cor[1]));

  int n_tests = 0;
  int n_fail  = 0;

  // reference model: unknown bits tracked as a separate flag per word and per output
  int            ma [2] = '{0, 1};
  int            mb [2] = '{0, 2};
  logic [DW-1:0] m_mem [2][DEPTH];
  bit            m_unk [2][DEPTH];
  logic [DW-1:0] e_ra [2];
  logic [DW-1:0] e_rb [2];
  bit            e_ua [2];
  bit            e_ub [2];
  bit            e_col, e_cor;

  task automatic chk_word(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp, bit unk);
    if (!unk) begin
      n_tests++;
      if (act !== exp) begin
        n_fail++;
        $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
    end
  endtask

  task automatic chk_bit(string tag, string what, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    for (int i = 0; i < 2; i++) begin
      chk_word(tag, $sformatf("inst%0d a_rdata", i), ra[i], e_ra[i], e_ua[i]);
      chk_word(tag, $sformatf("inst%0d b_rdata", i), rb[i], e_rb[i], e_ub[i]);
      chk_bit(tag, $sformatf("inst%0d collide", i), col[i], e_col);
      chk_bit(tag, $sformatf("inst%0d corrupt", i), cor[i], e_cor);
    end
  endtask

  task automatic cyc(bit e0, bit w0, int a0, int d0, bit e1, bit w1, int a1, int d1, string tag);
    bit hit, clash;
    ae = e0; awe = w0; aa = AW'(a0); ad = DW'(d0);
    be = e1; bwe = w1; ba = AW'(a1); bd = DW'(d1);
    hit   = ae && be && (aa == ba);
    clash = hit && awe && bwe;
    for (int i = 0; i < 2; i++) begin
      logic [DW-1:0] oa, ob, na, nb;
      bit uoa, uob, nua, nub;
      oa = m_mem[i][aa]; uoa = m_unk[i][aa];
      ob = m_mem[i][ba]; uob = m_unk[i][ba];
      na = e_ra[i]; nua = e_ua[i];
      nb = e_rb[i]; nub = e_ub[i];
      if (ae) begin
        if (!awe || ma[i] == 0) begin na = oa; nua = uoa; end
        else if (ma[i] == 1) begin na = ad; nua = 0; end
        if (clash || (hit && !awe && bwe && mb[i] != 0)) nua = 1;
      end
      if (be) begin
        if (!bwe || mb[i] == 0) begin nb = ob; nub = uob; end
        else if (mb[i] == 1) begin nb = bd; nub = 0; end
        if (clash || (hit && !bwe && awe && ma[i] != 0)) nub = 1;
      end
      if (clash) m_unk[i][aa] = 1;
      else begin
        if (ae && awe) begin m_mem[i][aa] = ad; m_unk[i][aa] = 0; end
        if (be && bwe) begin m_mem[i][ba] = bd; m_unk[i][ba] = 0; end
      end
      e_ra[i] = na; e_ua[i] = nua;
      e_rb[i] = nb; e_ub[i] = nub;
    end
    e_col = hit; e_cor = clash;
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 2; i++) begin
      e_ra[i] = '0; e_rb[i] = '0; e_ua[i] = 0; e_ub[i] = 0;
      for (int k = 0; k < DEPTH; k++) m_unk[i][k] = 1;
    end
    e_col = 0; e_cor = 0;
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk);
    compare("R1 after release");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R1 idle");
  endtask

  task automatic t_plain();
    cyc(1, 1, 'h10, 'h1111, 0, 0, 0, 0, "R2 seed");
    cyc(0, 0, 0, 0, 1, 0, 'h10, 0, "R2 read B");
    cyc(1, 0, 'h10, 0, 0, 0, 0, 0, "R2 read A");
  endtask

  task automatic t_modes();
    cyc(1, 1, 'h20, 'haaaa, 0, 0, 0, 0, "R4 first write");
    cyc(1, 1, 'h20, 'hbbbb, 0, 0, 0, 0, "R3 R4 R11 overwrite A");
    cyc(0, 0, 0, 0, 1, 0, 'h20, 0, "R3 landed");
    cyc(0, 0, 0, 0, 1, 1, 'h21, 'hcccc, "R5 first write B");
    cyc(0, 0, 0, 0, 1, 1, 'h21, 'hdddd, "R3 R5 R11 overwrite B");
    cyc(1, 0, 'h21, 0, 0, 0, 0, 0, "R5 landed");
  endtask

  task automatic t_disable();
    cyc(0, 1, 'h20, 'h5555, 0, 1, 'h21, 'h6666, "R6 disabled writes");
    cyc(1, 0, 'h20, 0, 1, 0, 'h21, 0, "R6 contents intact");
    cyc(0, 0, 'h21, 0, 0, 0, 'h20, 0, "R6 outputs held");
  endtask

  task automatic t_coll_rd();
    cyc(1, 0, 'h20, 0, 1, 0, 'h20, 0, "R7 R8 both read");
    cyc(1, 0, 'h20, 0, 1, 0, 'h21, 0, "R7 R8 distinct addr");
    cyc(1, 0, 'h20, 0, 0, 0, 'h20, 0, "R7 one port off");
  endtask

  task automatic t_coll_wr();
    cyc(1, 1, 'h30, 'h0f0f, 1, 1, 'h31, 'hf0f0, "R10 distinct writes");
    cyc(1, 1, 'h30, 'h1234, 1, 0, 'h30, 0, "R9 A writes B reads");
    cyc(1, 0, 'h30, 0, 1, 0, 'h31, 0, "R9 read back");
    cyc(1, 0, 'h31, 0, 1, 1, 'h31, 'h4321, "R9 B writes A reads");
    cyc(1, 0, 'h31, 0, 1, 0, 'h30, 0, "R9 read back 2");
  endtask

  task automatic t_coll_ww();
    cyc(1, 1, 'h40, 'h1111, 1, 1, 'h40, 'h2222, "R10 double write");
    cyc(1, 0, 'h40, 0, 1, 0, 'h41, 0, "R10 after clash");
    cyc(1, 1, 'h40, 'h7777, 0, 0, 0, 0, "R10 rewrite");
    cyc(0, 0, 0, 0, 1, 0, 'h40, 0, "R10 recovered");
  endtask

  task automatic t_sweep();
    for (int n = 0; n < 400; n++) begin
      cyc(bit'($urandom_range(0, 3) != 0), bit'($urandom_range(0, 1)), 'h50 + int'($urandom_range(0, 3)),
          int'($urandom_range(0, 65535)),
          bit'($urandom_range(0, 3) != 0), bit'($urandom_range(0, 1)), 'h50 + int'($urandom_range(0, 3)),
          int'($urandom_range(0, 65535)), "R9 sweep");
    end
  endtask

  initial begin
    t_reset();
    t_plain();
    t_modes();
    t_disable();
    t_coll_rd();
    t_coll_wr();
    t_coll_ww();
    t_sweep();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule